// File: doc/BRIEF.md
# Parallel Flash Read-Path Output Controller

This block is the read side of a parallel NOR-style flash device whose data bus runs either 16 bits or 8 bits wide. It decides, every clock, what the sixteen data pins carry and which of them are driven. The data comes from one of three places: the storage array, a status snapshot, or a two-byte identification code. The choice follows a read-mode input, an external busy flag, and the chip-enable, output-enable, write-enable and byte-mode pins.

In byte mode the top data pin stops being an output. It becomes the lowest address bit, which picks one byte of the addressed word, so the array shows twice as many locations. The status value is captured once, when a read becomes active, and it stays frozen until the read is broken and started again. Command decoding and the program and erase engines sit outside the block. The engine writes the array through a simple load port and reports its state through the busy flag and the status input. Every output is registered, one clock after the inputs it depends on.

Top module: `flash_read_port`

## Requirements
- R1: When write-enable (`we_n`) is low, or output-enable (`oe_n`) is high, or chip-enable (`ce_n`) is high, all sixteen pins are undriven (`dq_oe` = 16'h0000).
- R2: An array read in word mode (`byte_n` = 1) drives all sixteen pins (`dq_oe` = 16'hFFFF) with the word stored at `addr`.
- R3: An array read in byte mode (`byte_n` = 0) drives only bits 7..0 (`dq_oe` = 16'h00FF). It places the low byte of the word at `addr` when `dq15_in` = 0 and the high byte when `dq15_in` = 1.
- R4: While a read stays active, the array output follows every change of `addr`, one clock later.
- R5: A status read ignores `addr` and puts the status byte on bits 7..0. In word mode bits 15..8 are driven as zero. In byte mode only bits 7..0 are driven.
- R6: The status byte is taken from `stat_in` on the clock where the read turns active, which is when the later of `oe_n` and `ce_n` goes low. It then holds while the read stays active. Raising and lowering either enable takes a new snapshot.
- R7: An ID read uses only `addr[0]`. A value of 0 gives `MFR_ID` with upper byte 8'h00, and a value of 1 gives `DEV_ID` with upper byte 8'h88. In byte mode only bits 7..0 are driven.
- R8: While `busy` is high, a read returns status whatever the value of `mode`.
- R9: `mode` selects 2'b00 array, 2'b01 status and 2'b10 ID. The code 2'b11 reads the array.
- R10: After reset `dq_oe` and `dq_out` are zero. Each output reflects the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| byte_n | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| addr | input | ADDR_W | Word address |
| dq15_in | input | 1 | Top data pin used as byte-select address in byte mode |
| mode | input | 2 | Read mode selector |
| busy | input | 1 | Write/erase engine busy, forces status reads |
| stat_in | input | 8 | Live status value from the engine |
| ld_en | input | 1 | Array load strobe from the engine |
| ld_addr | input | ADDR_W | Array load address |
| ld_data | input | 16 | Array load word |
| dq_out | output | 16 | Data pin values |
| dq_oe | output | 16 | Per-pin output enables |

## Verification
Every pin result is due exactly one clock after the inputs are applied. The bench changes inputs on the falling edge, and the design captures them on the next rising edge. The monitor compares one nanosecond after that rising edge, and the scoreboard queue pairs each applied input set with the result it expects in that cycle. The status snapshot depends on the history of the enables. The bench model therefore tracks whether the previous cycle's read was active, and it re-latches only on an inactive-to-active step. Freeze and refresh are then checked against the value that was live when the read began.

// File: rtl/flash_read_port.sv
module flash_read_port #(
  parameter int          ADDR_W = 6,
  parameter logic [7:0]  MFR_ID = 8'h2C,
  parameter logic [7:0]  DEV_ID = 8'hA7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              byte_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              dq15_in,
  input  logic [1:0]        mode,
  input  logic              busy,
  input  logic [7:0]        stat_in,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [15:0]       ld_data,
  output logic [15:0]       dq_out,
  output logic [15:0]       dq_oe
);
  localparam int         DEPTH    = 1 << ADDR_W;
  localparam logic [1:0] MD_STAT  = 2'b01;
  localparam logic [1:0] MD_ID    = 2'b10;
  localparam logic [15:0] OE_WORD = 16'hFFFF;
  localparam logic [15:0] OE_BYTE = 16'h00FF;

  logic [15:0] mem [DEPTH];
  logic        rd_prev;
  logic [7:0]  stat_q;
  logic [15:0] nxt_dat, nxt_oe;

  always_ff @(posedge clk)
    if (ld_en) mem[ld_addr] <= ld_data;

  wire        rd_act = we_n & ~oe_n & ~ce_n;
  wire        snap   = rd_act & ~rd_prev;
  wire [7:0]  stat_v = snap ? stat_in : stat_q;
  wire [1:0]  eff    = busy ? MD_STAT : mode;
  wire [15:0] word   = mem[addr];
  wire [7:0]  id_lo  = addr[0] ? DEV_ID : MFR_ID;
  wire [7:0]  id_hi  = addr[0] ? 8'h88 : 8'h00;
  wire [7:0]  arr_b  = dq15_in ? word[15:8] : word[7:0];

  always_comb begin
    nxt_oe  = '0;
    nxt_dat = '0;
    if (rd_act) begin
      nxt_oe = byte_n ? OE_WORD : OE_BYTE;
      case (eff)
        MD_STAT: nxt_dat = {8'h00, stat_v};
        MD_ID:   nxt_dat = byte_n ? {id_hi, id_lo} : {8'h00, id_lo};
        default: nxt_dat = byte_n ? word : {8'h00, arr_b};
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_prev <= 1'b0;
      stat_q  <= '0;
      dq_oe   <= '0;
      dq_out  <= '0;
    end else begin
      rd_prev <= rd_act;
      if (snap) stat_q <= stat_in;
      dq_oe   <= nxt_oe;
      dq_out  <= nxt_dat;
    end

  // R1
  idle_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_act |=> dq_oe == 16'h0000);
  // R2
  word_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_act && byte_n) |=> dq_oe == 16'hFFFF);
  // R3
  byte_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_act && !byte_n) |=> dq_oe == 16'h00FF);
  // R5
  stat_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_act && byte_n && (busy || mode == 2'b01)) |=> dq_out[15:8] == 8'h00);
  // R6
  stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_act && rd_prev) |=> $stable(stat_q));
  // R7
  id_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_act && byte_n && !busy && mode == 2'b10 && addr[0]) |=> dq_out == {8'h88, DEV_ID});
endmodule

// File: tb/tb_flash_read_port.sv
module tb_flash_read_port;
  localparam int ADDR_W = 6;
  localparam logic [7:0] MFR = 8'h2C, DEV = 8'hA7;

  logic clk = 0, rst_n = 0;
  logic ce_n = 1, oe_n = 1, we_n = 1, byte_n = 1, dq15_in = 0, busy = 0, ld_en = 0;
  logic [ADDR_W-1:0] addr = '0, ld_addr = '0;
  logic [1:0] mode = 2'b00;
  logic [7:0] stat_in = '0;
  logic [15:0] ld_data = '0, dq_out, dq_oe;

  int checks = 0, fails = 0;
  logic [15:0] model [64];
  logic        m_prev = 0;
  logic [7:0]  m_stat = 0;

  logic [15:0] q_oe[$], q_dat[$];
  bit          q_chk[$];
  string       q_req[$];

  always #2 clk = ~clk;

  flash_read_port #(.ADDR_W(ADDR_W), .MFR_ID(MFR), .DEV_ID(DEV)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .byte_n(byte_n),
    .addr(addr), .dq15_in(dq15_in), .mode(mode), .busy(busy), .stat_in(stat_in),
    .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data), .dq_out(dq_out), .dq_oe(dq_oe));

  task automatic step(input logic c, input logic o, input logic w, input logic b,
                      input logic [ADDR_W-1:0] a, input logic a15, input logic [1:0] md,
                      input logic bz, input logic [7:0] st, input bit chk, input string req);
    logic act;
    logic [15:0] eo, ed, wd;
    logic [1:0] em;
    logic [7:0] id;
    @(negedge clk);
    ce_n = c; oe_n = o; we_n = w; byte_n = b; addr = a; dq15_in = a15;
    mode = md; busy = bz; stat_in = st; ld_en = 0;
    act = w && !o && !c;
    if (act && !m_prev) m_stat = st;
    m_prev = act;
    em = bz ? 2'b01 : md;
    wd = model[a];
    id = a[0] ? DEV : MFR;
    eo = 16'h0; ed = 16'h0;
    if (act) begin
      eo = b ? 16'hFFFF : 16'h00FF;
      if (em == 2'b01) ed = {8'h00, m_stat};
      else if (em == 2'b10) ed = b ? {(a[0] ? 8'h88 : 8'h00), id} : {8'h00, id};
      else ed = b ? wd : {8'h00, (a15 ? wd[15:8] : wd[7:0])};
    end
    q_oe.push_back(eo); q_dat.push_back(ed); q_chk.push_back(chk); q_req.push_back(req);
  endtask

  task automatic load(input logic [ADDR_W-1:0] a, input logic [15:0] d);
    @(negedge clk);
    ce_n = 1; ld_en = 1; ld_addr = a; ld_data = d;
    model[a] = d;
    m_prev = 0;
  endtask

  initial begin
    forever begin
      @(posedge clk); #1;
      if (q_oe.size() > 0) begin
        logic [15:0] eo, ed;
        bit c;
        string r;
        eo = q_oe.pop_front(); ed = q_dat.pop_front(); c = q_chk.pop_front(); r = q_req.pop_front();
        if (c) begin
          checks++;
          if (dq_oe !== eo || (dq_out & eo) !== ed) begin
            fails++;
            $display("FAIL %s: oe=%h dq=%h expected oe=%h dq=%h", r, dq_oe, dq_out & eo, eo, ed);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (dq_oe !== 16'h0 || dq_out !== 16'h0) begin
      fails++;
      $display("FAIL R10: oe=%h dq=%h expected oe=0000 dq=0000", dq_oe, dq_out);
    end
    @(negedge clk); rst_n = 1;
    for (int i = 0; i < 16; i++) load(i[ADDR_W-1:0], 16'(i * 16'h1357) ^ 16'hA5C3);
    @(negedge clk); ld_en = 0;
    // R2 R4: consecutive addresses while active
    for (int i = 0; i < 6; i++) step(0,0,1,1, i[ADDR_W-1:0],0,2'b00,0,8'h11,1,"R2/R4");
    // R1: each disable condition
    step(0,0,0,1, 6'd3,0,2'b00,0,8'h11,1,"R1 we low");
    step(1,0,1,1, 6'd3,0,2'b00,0,8'h11,1,"R1 ce high");
    step(0,1,1,1, 6'd3,0,2'b00,0,8'h11,1,"R1 oe high");
    // R3: byte mode selection
    step(0,0,1,0, 6'd5,0,2'b00,0,8'h11,1,"R3 low byte");
    step(0,0,1,0, 6'd5,1,2'b00,0,8'h11,1,"R3 high byte");
    step(0,0,1,0, 6'd9,1,2'b00,0,8'h11,1,"R3/R4 high byte new addr");
    // R9: code 11 reads array
    step(0,0,1,1, 6'd7,0,2'b11,0,8'h11,1,"R9 code 11");
    step(0,0,1,1, 6'd8,0,2'b00,0,8'h11,1,"R9 code 00");
    // R5 R6: status read
    step(0,1,1,1, 6'd0,0,2'b01,0,8'h5A,1,"R1 before status");
    step(0,0,1,1, 6'd4,0,2'b01,0,8'h5A,1,"R5 R6 snapshot");
    step(0,0,1,1, 6'd9,0,2'b01,0,8'h3C,1,"R6 hold, R5 addr ignored");
    step(0,0,1,1, 6'd2,0,2'b01,0,8'h77,1,"R6 hold");
    step(1,0,1,1, 6'd2,0,2'b01,0,8'h77,1,"R6 ce toggle high");
    step(0,0,1,1, 6'd2,0,2'b01,0,8'h77,1,"R6 refresh on ce low");
    step(0,0,1,0, 6'd2,1,2'b01,0,8'h81,1,"R5 byte mode status");
    step(0,1,1,0, 6'd2,1,2'b01,0,8'h81,1,"R1 oe high");
    step(0,0,1,0, 6'd2,1,2'b01,0,8'h81,1,"R5 R6 byte mode refresh");
    // R7: identification
    step(0,0,1,1, 6'd0,0,2'b10,0,8'h00,1,"R7 mfr word");
    step(0,0,1,1, 6'd1,0,2'b10,0,8'h00,1,"R7 dev word");
    step(0,0,1,1, 6'd6,0,2'b10,0,8'h00,1,"R7 mfr addr[0]=0 only");
    step(0,0,1,0, 6'd1,1,2'b10,0,8'h00,1,"R7 dev byte");
    step(0,0,1,0, 6'd0,0,2'b10,0,8'h00,1,"R7 mfr byte");
    // R8: busy forces status
    step(1,1,1,1, 6'd3,0,2'b00,1,8'hC4,1,"R1 idle");
    step(0,0,1,1, 6'd3,0,2'b00,1,8'hC4,1,"R8 busy over array");
    step(0,0,1,1, 6'd3,0,2'b10,1,8'h99,1,"R8 busy over ID");
    step(0,0,1,1, 6'd3,0,2'b00,0,8'h99,1,"R8 busy released, array");
    step(1,1,1,1, 6'd0,0,2'b00,0,8'h00,0,"drain");
    @(negedge clk); @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule